// File: doc/BRIEF.md
# Pulse Phase-Difference Tracking Detector

This block measures the time offset between two digitized pulse streams, channel A and channel B, against a fast reference clock. A measurement opens when one channel changes level while both channels agree. It closes when the other channel follows. The number of clock cycles between the two changes is multiplied by a programmable coefficient and divided by a range factor. The result is signed: positive when A moved first, negative when B moved first. It is then held on `out_word` until the next accepted measurement.

Malformed transitions never reach the output, and the output keeps its previous value in these cases:
- the first channel toggles again before the second one moves;
- the offset is shorter than a minimum count;
- the offset runs past a maximum count.

A low `enable` or a high `defect` forces the output to the zero reference code. Measurements that complete while forced are dropped.

The result flows out as a held level with a one-cycle strobe. There is no back-pressure: the sampled edges are physical events that cannot be stalled. A consumer must take the value on the strobe cycle or read the held level later. `pulse_a` and `pulse_b` are taken to be synchronous to `clk`.

Top module: `pd_tracker`

## Requirements
- R1: After reset, `out_word` is 0 and `out_valid` is low.
- R2: A measurement starts when exactly one input changes level while both inputs were equal. It ends when the other input changes.
  - The offset d is the number of clock edges between the edge that registers the first change and the edge that registers the second.
  - The result appears on `out_word` right after the edge that registers the second change. `out_valid` is high for that one cycle only.
  - An edge arriving while the inputs differ, with no measurement open, starts nothing.
- R3: The result is positive when A changed first and negative (two's complement) when B changed first.
- R4: The coefficient code `coef_sel` 0..7 selects a quarter-unit factor C of 22, 30, 43, 61, 86, 121, 171 or 242. With no range division, the magnitude is d*C.
- R5: `range_sel` values 0, 1, 2 and 3 divide the magnitude by 1, 2, 4 and 8. The division is a right shift by `range_sel` applied after the product: |result| = (d*C) >> range_sel.
- R6: If the channel that moved first toggles again before the other channel moves, no result is produced and `out_word` keeps its value.
- R7: A pair with d < MIN_CNT (default 2), including simultaneous changes, is discarded and `out_word` is held.
- R8: A measurement whose count reaches MAX_CNT (default 63) without the second change is aborted. d = MAX_CNT is still accepted. No result is produced.
- R9: While `enable` is low or `defect` is high, `out_word` is 0 from the next edge on and `out_valid` stays low. Pairs that complete in that time produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_a | input | 1 | Digitized channel A pulse stream |
| pulse_b | input | 1 | Digitized channel B pulse stream |
| defect | input | 1 | High forces output to zero |
| enable | input | 1 | Low forces output to zero |
| coef_sel | input | 3 | Time-to-value coefficient code |
| range_sel | input | 2 | Coefficient divider, shift by 0..3 |
| out_word | output | OUT_W (15) | Signed held result |
| out_valid | output | 1 | One-cycle strobe on each accepted result |

## Verification
The measurement close and the force condition can land on the same clock edge: a second-channel change registered while `defect` is high or `enable` is low. The bench provokes this by completing a full pair while `defect` is high. It counts strobes in that window and expects none, with `out_word` at zero. A further pair after release must then yield its full scaled value. A second collision is an abort and a second-channel edge arriving together. The bench provokes it with simultaneous edges and with a re-toggle, and judges it by an unchanged strobe count and an unchanged held word.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    PD_IDLE  = 2'd0,
    PD_RUN_A = 2'd1,
    PD_RUN_B = 2'd2
  } pd_state_e;

  localparam int COEF_W = 8;

  // Quarter-unit coefficient, steps of about sqrt(2)
  function automatic logic [COEF_W-1:0] coef_q2(input logic [2:0] code);
    logic [COEF_W-1:0] c;
    case (code)
      3'd0:    c = 8'd22;
      3'd1:    c = 8'd30;
      3'd2:    c = 8'd43;
      3'd3:    c = 8'd61;
      3'd4:    c = 8'd86;
      3'd5:    c = 8'd121;
      3'd6:    c = 8'd171;
      default: c = 8'd242;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pd_edge_det.sv
module pd_edge_det #(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] lvl_in,
  output logic [N_CH-1:0] lvl_q,
  output logic [N_CH-1:0] chg
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl_in[i];
    end
    assign chg[i] = lvl_in[i] ^ lvl_q[i];
  end
endmodule

// File: rtl/pd_interval.sv
module pd_interval
  import pd_pkg::*;
#(
  parameter int MIN_CNT = 2,
  parameter int MAX_CNT = 63,
  localparam int CNT_W  = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lvl_q,
  input  logic [1:0]       chg,
  output logic             done,
  output logic             lead_a,
  output logic [CNT_W-1:0] span
);
  pd_state_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             own_chg, oth_chg;

  always_comb begin
    own_chg = (st == PD_RUN_A) ? chg[0] : chg[1];
    oth_chg = (st == PD_RUN_A) ? chg[1] : chg[0];
  end

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    done  = 1'b0;
    unique case (st)
      PD_IDLE: begin
        if (lvl_q[0] == lvl_q[1]) begin
          if (chg[0] && !chg[1]) begin
            st_n  = PD_RUN_A;
            cnt_n = CNT_W'(1);
          end else if (chg[1] && !chg[0]) begin
            st_n  = PD_RUN_B;
            cnt_n = CNT_W'(1);
          end
        end
      end
      PD_RUN_A, PD_RUN_B: begin
        if (own_chg) begin
          st_n = PD_IDLE;                       // re-toggle: abnormal
        end else if (oth_chg) begin
          st_n = PD_IDLE;
          done = (cnt >= CNT_W'(MIN_CNT));
        end else if (cnt == CNT_W'(MAX_CNT)) begin
          st_n = PD_IDLE;                       // too long: abnormal
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      default: st_n = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= PD_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign lead_a = (st == PD_RUN_A);
  assign span   = cnt;
endmodule

// File: rtl/pd_scale.sv
module pd_scale
  import pd_pkg::*;
#(
  parameter int CNT_W = 6,
  localparam int PROD_W = CNT_W + COEF_W,
  localparam int OUT_W  = PROD_W + 1
) (
  input  logic [CNT_W-1:0]        span,
  input  logic                    lead_a,
  input  logic [2:0]              coef_sel,
  input  logic [1:0]              range_sel,
  output logic signed [OUT_W-1:0] value
);
  logic [PROD_W-1:0] prod, mag;
  logic signed [OUT_W-1:0] smag;

  always_comb begin
    prod  = PROD_W'(span) * PROD_W'(coef_q2(coef_sel));
    mag   = prod >> range_sel;
    smag  = signed'({1'b0, mag});
    value = lead_a ? smag : -smag;
  end
endmodule

// File: rtl/pd_tracker.sv
module pd_tracker
  import pd_pkg::*;
#(
  parameter int MIN_CNT = 2,
  parameter int MAX_CNT = 63,
  localparam int CNT_W  = $clog2(MAX_CNT + 1),
  localparam int OUT_W  = CNT_W + COEF_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pulse_a,
  input  logic                    pulse_b,
  input  logic                    defect,
  input  logic                    enable,
  input  logic [2:0]              coef_sel,
  input  logic [1:0]              range_sel,
  output logic signed [OUT_W-1:0] out_word,
  output logic                    out_valid
);
  logic [1:0]              lvl_q, chg;
  logic                    done, lead_a, force_ref;
  logic [CNT_W-1:0]        span;
  logic signed [OUT_W-1:0] value;

  pd_edge_det #(.N_CH(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_in({pulse_b, pulse_a}),
    .lvl_q(lvl_q), .chg(chg)
  );

  pd_interval #(.MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT)) u_int (
    .clk(clk), .rst_n(rst_n), .lvl_q(lvl_q), .chg(chg),
    .done(done), .lead_a(lead_a), .span(span)
  );

  pd_scale #(.CNT_W(CNT_W)) u_scale (
    .span(span), .lead_a(lead_a), .coef_sel(coef_sel),
    .range_sel(range_sel), .value(value)
  );

  assign force_ref = !enable || defect;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else if (force_ref) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else if (done) begin
      out_word  <= value;
      out_valid <= 1'b1;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pd_tracker_chk.sv
module pd_tracker_chk #(
  parameter int OUT_W = 15
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    defect,
  input logic                    enable,
  input logic signed [OUT_W-1:0] out_word,
  input logic                    out_valid
);
  // R9: forced output is zero with no strobe
  assert_force_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || defect) |=> (out_word == '0 && !out_valid));

  // R9: a strobe implies the force was inactive
  assert_strobe_unforced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(enable) && !$past(defect)));

  // R2: strobe lasts one cycle
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: without a strobe and without force, the word is held
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(enable) && !$past(defect)) |-> $stable(out_word));

  // R3: accepted results are never zero (d >= MIN_CNT, C >= 22)
  assert_signed_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word != '0));
endmodule

bind pd_tracker pd_tracker_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .defect(defect), .enable(enable),
  .out_word(out_word), .out_valid(out_valid)
);

// File: tb/pd_tracker_test.sv
module pd_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_CNT    = 2;
  localparam int MAX_CNT    = 63;
  localparam int OUT_W      = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, defect = 1'b0, enable = 1'b0;
  logic [2:0] coef_sel = 3'd3;
  logic [1:0] range_sel = 2'd0;
  logic signed [OUT_W-1:0] out_word;
  logic out_valid;

  int checks = 0, fails = 0, vcount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_tracker #(.MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT)) uut (
    .clk(clk), .rst_n(rst_n), .pulse_a(pa), .pulse_b(pb),
    .defect(defect), .enable(enable), .coef_sel(coef_sel),
    .range_sel(range_sel), .out_word(out_word), .out_valid(out_valid)
  );

  always @(negedge clk) if (out_valid) vcount++;

  function automatic int coef_of(int c);
    case (c)
      0: return 22;  1: return 30;  2: return 43;  3: return 61;
      4: return 86;  5: return 121; 6: return 171; default: return 242;
    endcase
  endfunction

  function automatic int expect_val(int d, int c, int r, bit a_first);
    int m;
    m = (d * coef_of(c)) >> r;
    return a_first ? m : -m;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pair(bit a_first, int d);
    @(negedge clk);
    if (a_first) pa = ~pa; else pb = ~pb;
    repeat (d) @(negedge clk);
    if (a_first) pb = ~pb; else pa = ~pa;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev, vc, exp;
    int dl[4];
    dl = '{MIN_CNT, 5, 17, MAX_CNT};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_word == 0, "R1 reset word", int'(out_word), 0);
    chk(out_valid == 0, "R1 reset strobe", int'(out_valid), 0);
    enable = 1'b1;

    // R2 R3 R4 R5 sweep
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 4; r++) begin
        coef_sel = 3'(c); range_sel = 2'(r);
        for (int k = 0; k < 4; k++) begin
          for (int s = 0; s < 2; s++) begin
            exp = expect_val(dl[k], c, r, s == 0);
            pair(s == 0, dl[k]);
            chk(int'(out_word) == exp, "R4 R5 R3 scaled value", int'(out_word), exp);
            chk(out_valid == 1'b1, "R2 strobe on close", int'(out_valid), 1);
          end
        end
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 strobe one cycle", int'(out_valid), 0);
    prev = int'(out_word);

    // R7 too short and simultaneous
    vc = vcount;
    pair(1'b1, 1);
    @(negedge clk); pa = ~pa; pb = ~pb;
    repeat (3) @(negedge clk);
    chk(vcount == vc, "R7 short pairs no strobe", vcount - vc, 0);
    chk(int'(out_word) == prev, "R7 held word", int'(out_word), prev);

    // R6 re-toggle of the first channel
    vc = vcount;
    @(negedge clk); pb = ~pb;
    repeat (2) @(negedge clk); pb = ~pb;
    repeat (4) @(negedge clk);
    chk(vcount == vc, "R6 re-toggle no strobe", vcount - vc, 0);
    chk(int'(out_word) == prev, "R6 held word", int'(out_word), prev);

    // R8 overrun; later B edge under disagreement starts nothing
    vc = vcount;
    @(negedge clk); pa = ~pa;
    repeat (MAX_CNT + 3) @(negedge clk); pb = ~pb;
    repeat (3) @(negedge clk);
    chk(vcount == vc, "R8 overrun no strobe", vcount - vc, 0);
    chk(int'(out_word) == prev, "R8 held word", int'(out_word), prev);

    // R9 defect forcing, with a pair closing while forced
    coef_sel = 3'd3; range_sel = 2'd0;
    defect = 1'b1;
    @(negedge clk);
    chk(out_word == 0, "R9 defect forces zero", int'(out_word), 0);
    vc = vcount;
    pair(1'b1, 5);
    chk(vcount == vc, "R9 no strobe while forced", vcount - vc, 0);
    chk(out_word == 0, "R9 zero while forced", int'(out_word), 0);
    defect = 1'b0;
    exp = expect_val(4, 3, 0, 1'b0);
    pair(1'b0, 4);
    chk(int'(out_word) == exp, "R9 after release", int'(out_word), exp);
    enable = 1'b0;
    @(negedge clk);
    chk(out_word == 0, "R9 enable low forces zero", int'(out_word), 0);
    enable = 1'b1;
    exp = expect_val(9, 3, 0, 1'b1);
    pair(1'b1, 9);
    chk(int'(out_word) == exp, "R2 default coefficient", int'(out_word), exp);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule